// File: doc/BRIEF.md
# Filter Match Index Priority Resolver

This block sits behind the identifier comparators of a CAN-style receive path. Every filter bank reports, for each of its sub-filters, whether the incoming identifier matched. The bank also reports its comparison width, its mode, the receive FIFO it feeds and whether it is enabled. When a frame-valid strobe arrives, the resolver picks exactly one winning sub-filter. It then reports which FIFO the frame goes to and the winner's filter match index, which is its position in that FIFO's filter numbering. If no enabled sub-filter matched, it signals that the frame is dropped.

A bank holds a different number of sub-filters depending on its configuration: one for 32-bit mask, two for 32-bit list, two for 16-bit mask and four for 16-bit list. Each FIFO has its own numbering. The numbering walks the banks that feed that FIFO in ascending bank order, and the sub-filters within a bank in ascending order. A disabled bank still uses up its numbers, so software can work out the indices from the configuration alone. When several sub-filters match, wider filters win over narrower ones, list filters win over mask filters of the same width, and lower numbers win after that.

Top module: `fmi_resolver`

## Requirements
- R1: Match flag `match_i[4*b+k]` is sub-filter k of bank b. `wide_i[b]`=1 selects the 32-bit width and `list_i[b]`=1 selects list mode. A bank contributes 1, 2, 2 or 4 sub-filters for 32-bit mask, 32-bit list, 16-bit mask and 16-bit list respectively. The reported index equals the number of sub-filters in lower banks that feed the same FIFO, plus k.
- R2: Disabled banks (`active_i[b]`=0) never win, but they still count toward the index of every later bank on the same FIFO.
- R3: Index numbering is independent for each FIFO (`fifo_i[b]`: 0 or 1). `fifo_sel_o` reports the FIFO of the winning bank.
- R4: A matching 32-bit sub-filter wins over any matching 16-bit sub-filter.
- R5: At equal width, a matching list-mode sub-filter wins over any matching mask-mode sub-filter.
- R6: At equal width and mode, the lower bank wins, and within a bank the lower sub-filter wins.
- R7: When no enabled sub-filter matches, `discard_o` pulses and `accept_o` stays low.
- R8: Match flags at sub-filter positions a bank does not have under its current width and mode have no effect.
- R9: `accept_o` or `discard_o` is high for exactly the one cycle after each cycle with `frame_valid_i` high, never both, and is never high otherwise. Frames may arrive on back-to-back cycles.
- R10: While `accept_o` is low, `fifo_sel_o` and `fmi_o` hold the values of the last accepted frame.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid_i | input | 1 | Frame identifier has been compared; inputs are valid this cycle |
| match_i | input | 4*NUM_BANKS | Per-sub-filter match flags, bit 4*b+k for bank b, sub-filter k |
| wide_i | input | NUM_BANKS | 1 = bank compares 32-bit, 0 = two/four 16-bit |
| list_i | input | NUM_BANKS | 1 = identifier list mode, 0 = mask mode |
| fifo_i | input | NUM_BANKS | Target receive FIFO of each bank |
| active_i | input | NUM_BANKS | 1 = bank enabled |
| accept_o | output | 1 | Frame accepted (one-cycle pulse) |
| discard_o | output | 1 | Frame dropped (one-cycle pulse) |
| fifo_sel_o | output | 1 | FIFO of the winning filter |
| fmi_o | output | IDX_W | Filter match index of the winner |

## Verification
Two functions can fall in the same cycle. One is the output of a previous frame's result. The other is the capture of the next frame, or the holding of index and FIFO after a drop. The bench provokes this with pseudo-random configurations over a four-bank instance. Half of those frames are issued on back-to-back cycles, and the bench checks that the first result appears intact while the second frame is sampled. An arithmetic model in the bench enumerates each FIFO's numbering and ranks candidates by a numeric key. Each result is compared with that model, and after every drop the index and FIFO outputs are compared with the last accepted values.

// File: rtl/fmi_pkg.sv
package fmi_pkg;

    localparam int SUBS = 4;

    // Ranking of a bank configuration; higher value wins.
    typedef enum logic [1:0] {
        TIER_N_MASK = 2'd0,
        TIER_N_LIST = 2'd1,
        TIER_W_MASK = 2'd2,
        TIER_W_LIST = 2'd3
    } tier_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] sub;
        tier_e      tier;
    } bank_res_t;

    // Number of sub-filters a bank provides for a width/mode pair.
    function automatic logic [2:0] sub_count(input logic wide, input logic list);
        logic [2:0] n;
        case ({wide, list})
            2'b10:   n = 3'd1;
            2'b11:   n = 3'd2;
            2'b00:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    function automatic tier_e tier_of(input logic wide, input logic list);
        return tier_e'({wide, list});
    endfunction

endpackage

// File: rtl/fmi_bank_eval.sv
module fmi_bank_eval
    import fmi_pkg::*;
(
    input  logic [SUBS-1:0] match_i,
    input  logic            wide_i,
    input  logic            list_i,
    input  logic            active_i,
    output bank_res_t       res_o
);

    logic [2:0]      n_subs;
    logic [SUBS-1:0] lanes;
    logic [SUBS-1:0] live;

    always_comb begin
        n_subs = sub_count(wide_i, list_i);
        for (int k = 0; k < SUBS; k++) begin
            lanes[k] = (k < int'(n_subs));
        end
        live = match_i & lanes & {SUBS{active_i}};

        res_o.hit  = |live;
        res_o.tier = tier_of(wide_i, list_i);
        res_o.sub  = '0;
        for (int k = SUBS - 1; k >= 0; k--) begin
            if (live[k]) begin
                res_o.sub = 2'(k);
            end
        end
    end

endmodule

// File: rtl/fmi_index_map.sv
module fmi_index_map
    import fmi_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int IDX_W     = 8
) (
    input  logic [NUM_BANKS-1:0] wide_i,
    input  logic [NUM_BANKS-1:0] list_i,
    input  logic [NUM_BANKS-1:0] fifo_i,
    output logic [IDX_W-1:0]     base_o [NUM_BANKS]
);

    logic [IDX_W-1:0] run0;
    logic [IDX_W-1:0] run1;
    logic [IDX_W-1:0] step;

    // Activation is deliberately not an input: every bank consumes numbers.
    always_comb begin
        run0 = '0;
        run1 = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            step = IDX_W'(sub_count(wide_i[b], list_i[b]));
            if (fifo_i[b]) begin
                base_o[b] = run1;
                run1      = run1 + step;
            end else begin
                base_o[b] = run0;
                run0      = run0 + step;
            end
        end
    end

endmodule

// File: rtl/fmi_winner_sel.sv
module fmi_winner_sel
    import fmi_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  bank_res_t         res_i [NUM_BANKS],
    output logic              found_o,
    output logic [BANK_W-1:0] bank_o
);

    logic [1:0] best_tier;

    // Ascending scan; only a strictly better tier displaces the holder,
    // so ties resolve to the lower bank.
    always_comb begin
        found_o   = 1'b0;
        bank_o    = '0;
        best_tier = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (res_i[b].hit && (!found_o || (2'(res_i[b].tier) > best_tier))) begin
                found_o   = 1'b1;
                bank_o    = BANK_W'(b);
                best_tier = 2'(res_i[b].tier);
            end
        end
    end

endmodule

// File: rtl/fmi_resolver.sv
module fmi_resolver
    import fmi_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int IDX_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_valid_i,
    input  logic [SUBS*NUM_BANKS-1:0] match_i,
    input  logic [NUM_BANKS-1:0]      wide_i,
    input  logic [NUM_BANKS-1:0]      list_i,
    input  logic [NUM_BANKS-1:0]      fifo_i,
    input  logic [NUM_BANKS-1:0]      active_i,
    output logic                      accept_o,
    output logic                      discard_o,
    output logic                      fifo_sel_o,
    output logic [IDX_W-1:0]          fmi_o
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef struct packed {
        logic             accept;
        logic             discard;
        logic             fifo;
        logic [IDX_W-1:0] fmi;
    } out_t;

    bank_res_t         bank_res [NUM_BANKS];
    logic [IDX_W-1:0]  bank_base [NUM_BANKS];
    logic              win_found;
    logic [BANK_W-1:0] win_bank;
    out_t              out_d;
    out_t              out_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        fmi_bank_eval u_eval (
            .match_i  (match_i[SUBS*b +: SUBS]),
            .wide_i   (wide_i[b]),
            .list_i   (list_i[b]),
            .active_i (active_i[b]),
            .res_o    (bank_res[b])
        );
    end

    fmi_index_map #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) u_map (
        .wide_i (wide_i),
        .list_i (list_i),
        .fifo_i (fifo_i),
        .base_o (bank_base)
    );

    fmi_winner_sel #(
        .NUM_BANKS (NUM_BANKS)
    ) u_sel (
        .res_i   (bank_res),
        .found_o (win_found),
        .bank_o  (win_bank)
    );

    always_comb begin
        out_d         = out_q;
        out_d.accept  = 1'b0;
        out_d.discard = 1'b0;
        if (frame_valid_i) begin
            if (win_found) begin
                out_d.accept = 1'b1;
                out_d.fifo   = fifo_i[win_bank];
                out_d.fmi    = bank_base[win_bank] + IDX_W'(bank_res[win_bank].sub);
            end else begin
                out_d.discard = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign accept_o   = out_q.accept;
    assign discard_o  = out_q.discard;
    assign fifo_sel_o = out_q.fifo;
    assign fmi_o      = out_q.fmi;

endmodule

// File: rtl/fmi_resolver_chk.sv
module fmi_resolver_chk #(
    parameter int NUM_BANKS = 28,
    parameter int IDX_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_valid_i,
    input logic [NUM_BANKS-1:0] active_i,
    input logic                 accept_o,
    input logic                 discard_o,
    input logic                 fifo_sel_o,
    input logic [IDX_W-1:0]     fmi_o
);

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && discard_o));

    // R9
    outcome_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_i |=> (accept_o || discard_o));

    // R9
    no_spurious_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || discard_o) |-> $past(frame_valid_i));

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |-> ($stable(fmi_o) && $stable(fifo_sel_o)));

    // R2
    accept_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ($past(active_i) != '0));

    // R7
    idle_banks_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && (active_i == '0)) |=> discard_o);

    // R1
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (int'(fmi_o) < 4 * NUM_BANKS));

endmodule

bind fmi_resolver fmi_resolver_chk #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_valid_i (frame_valid_i),
    .active_i      (active_i),
    .accept_o      (accept_o),
    .discard_o     (discard_o),
    .fifo_sel_o    (fifo_sel_o),
    .fmi_o         (fmi_o)
);

// File: tb/fmi_resolver_test.sv
module fmi_resolver_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int IW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_valid = 1'b0;
    logic [4*NB-1:0] match = '0;
    logic [NB-1:0] wide = '0;
    logic [NB-1:0] list = '0;
    logic [NB-1:0] fifo = '0;
    logic [NB-1:0] act = '0;
    logic          accept;
    logic          discard;
    logic          fifo_sel;
    logic [IW-1:0] fmi;

    int errors = 0;
    int checks = 0;
    int held_fmi = 0;
    int held_fifo = 0;
    logic [31:0] rng = 32'h1234_5679;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fmi_resolver #(.NUM_BANKS(NB), .IDX_W(IW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid_i (frame_valid),
        .match_i       (match),
        .wide_i        (wide),
        .list_i        (list),
        .fifo_i        (fifo),
        .active_i      (act),
        .accept_o      (accept),
        .discard_o     (discard),
        .fifo_sel_o    (fifo_sel),
        .fmi_o         (fmi)
    );

    task automatic check_eq(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Arithmetic model: enumerate each FIFO's numbers, rank by numeric key.
    function automatic void model(input logic [4*NB-1:0] m, input logic [NB-1:0] w,
                                  input logic [NB-1:0] l, input logic [NB-1:0] f,
                                  input logic [NB-1:0] a, output logic acc,
                                  output int fs, output int idx);
        int next_num [2];
        int best_key;
        next_num[0] = 0;
        next_num[1] = 0;
        best_key = 1 << 30;
        acc = 1'b0;
        fs = 0;
        idx = 0;
        for (int b = 0; b < NB; b++) begin
            int cnt;
            int pen;
            cnt = w[b] ? (l[b] ? 2 : 1) : (l[b] ? 4 : 2);
            pen = (w[b] ? 0 : 2) + (l[b] ? 0 : 1);
            for (int k = 0; k < cnt; k++) begin
                int num;
                int key;
                num = next_num[f[b]];
                next_num[f[b]] = next_num[f[b]] + 1;
                key = pen * 64 + b * 4 + k;
                if (a[b] && m[4*b+k] && key < best_key) begin
                    best_key = key;
                    acc = 1'b1;
                    fs = int'(f[b]);
                    idx = num;
                end
            end
        end
    endfunction

    // Sample a result after the edge that registered it (called at a negedge).
    task automatic check_result(input string req, input logic exp_acc,
                                input int exp_fifo, input int exp_idx);
        check_eq({req, " accept"}, int'(accept), int'(exp_acc));
        check_eq({req, " R7 discard"}, int'(discard), int'(!exp_acc));
        if (exp_acc) begin
            held_fifo = exp_fifo;
            held_fmi = exp_idx;
        end
        check_eq({req, " R3 fifo"}, int'(fifo_sel), held_fifo);
        check_eq({req, " R10 index"}, int'(fmi), held_fmi);
    endtask

    task automatic drive(input logic [4*NB-1:0] m, input logic [NB-1:0] w,
                         input logic [NB-1:0] l, input logic [NB-1:0] f,
                         input logic [NB-1:0] a, input logic v);
        match = m;
        wide = w;
        list = l;
        fifo = f;
        act = a;
        frame_valid = v;
    endtask

    task automatic directed(input string req, input logic [4*NB-1:0] m,
                            input logic [NB-1:0] w, input logic [NB-1:0] l,
                            input logic [NB-1:0] f, input logic [NB-1:0] a,
                            input logic exp_acc, input int exp_fifo, input int exp_idx);
        @(negedge clk);
        drive(m, w, l, f, a, 1'b1);
        @(negedge clk);
        frame_valid = 1'b0;
        check_result(req, exp_acc, exp_fifo, exp_idx);
    endtask

    task automatic random_cfg(output logic [4*NB-1:0] m, output logic [NB-1:0] w,
                              output logic [NB-1:0] l, output logic [NB-1:0] f,
                              output logic [NB-1:0] a);
        rng = next_rand(rng);
        m = rng[15:0];
        w = rng[19:16];
        l = rng[23:20];
        f = rng[27:24];
        rng = next_rand(rng);
        a = rng[3:0] | rng[7:4];
        if (rng[10:8] == 3'd0) a = '0;
        if (rng[13:11] == 3'd0) m = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [4*NB-1:0] m;
        logic [NB-1:0] w, l, f, a;
        logic ea;
        int ef, ei;

        repeat (3) @(negedge clk);
        // R11: reset state
        check_eq("R11 accept", int'(accept), 0);
        check_eq("R11 discard", int'(discard), 0);
        check_eq("R11 fifo", int'(fifo_sel), 0);
        check_eq("R11 index", int'(fmi), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R9 idle after reset", int'(accept | discard), 0);

        // Banks: 0=32 mask(1) 1=16 list(4) 2=32 list(2) 3=16 mask(2); bases 0,1,5,7
        directed("R1", 16'h2000, 4'b0101, 4'b0110, 4'b0000, 4'b1111, 1'b1, 0, 8);
        directed("R2", 16'h2000, 4'b0101, 4'b0110, 4'b0000, 4'b1000, 1'b1, 0, 8);
        directed("R3", 16'h2000, 4'b0101, 4'b0110, 4'b0110, 4'b1111, 1'b1, 0, 2);
        directed("R4 R3", 16'h2200, 4'b0101, 4'b0110, 4'b0110, 4'b1111, 1'b1, 1, 5);
        // bank0 16 list vs bank1 32 mask
        directed("R4", 16'h0011, 4'b0010, 4'b0001, 4'b0000, 4'b1111, 1'b1, 0, 4);
        // all 32-bit, bank3 list
        directed("R5", 16'h2001, 4'b1111, 4'b1000, 4'b0000, 4'b1111, 1'b1, 0, 4);
        directed("R6 bank", 16'h0110, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b1, 0, 1);
        directed("R6 sub", 16'h000A, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 1'b1, 0, 1);
        directed("R6 fifo tie", 16'h0011, 4'b1111, 4'b0000, 4'b0001, 4'b1111, 1'b1, 1, 0);
        directed("R7 inactive", 16'hFFFF, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 0, 0);
        directed("R7 no match", 16'h0000, 4'b1010, 4'b0110, 4'b0011, 4'b1111, 1'b0, 0, 0);
        directed("R8 wide mask", 16'hEEEE, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 0, 0);
        directed("R8 wide list", 16'hCCCC, 4'b1111, 4'b1111, 4'b0000, 4'b1111, 1'b0, 0, 0);
        directed("R8 narrow mask", 16'hCCCC, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 1'b0, 0, 0);
        @(negedge clk);
        check_eq("R9 single pulse", int'(accept | discard), 0);

        for (int i = 0; i < 3000; i++) begin
            random_cfg(m, w, l, f, a);
            model(m, w, l, f, a, ea, ef, ei);
            @(negedge clk);
            drive(m, w, l, f, a, 1'b1);
            if (i % 2 == 1) begin
                logic [4*NB-1:0] m2;
                logic [NB-1:0] w2, l2, f2, a2;
                logic ea2;
                int ef2, ei2;
                random_cfg(m2, w2, l2, f2, a2);
                model(m2, w2, l2, f2, a2, ea2, ef2, ei2);
                @(negedge clk);
                check_result("R9 back-to-back first", ea, ef, ei);
                drive(m2, w2, l2, f2, a2, 1'b1);
                @(negedge clk);
                frame_valid = 1'b0;
                check_result("R9 back-to-back second", ea2, ef2, ei2);
            end else begin
                @(negedge clk);
                frame_valid = 1'b0;
                check_result("R1 sweep", ea, ef, ei);
                random_cfg(m, w, l, f, a);
                drive(m, w, l, f, a, 1'b0);
                @(negedge clk);
                check_eq("R9 no frame no pulse", int'(accept | discard), 0);
                check_eq("R10 hold index", int'(fmi), held_fmi);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule